// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Flag Word

This block does arithmetic and logic on two operands. Each operation works on either a byte (low 8 bits) or a 16-bit word. A flag word sits next to it. Six status flags in that word describe the most recent result. Three control flags change only when a dedicated command asks for it.

The operations are add, add with carry-in, subtract, subtract with borrow-in, AND, OR, XOR and compare. An operation is issued with `op_valid`. Its result and status flags appear one clock later.

A separate three-bit command sets or clears the carry, direction or interrupt-enable flag. A command may share a cycle with an operation.

Top module: `arith_flag_unit`

## Requirements
- R1: With `op_valid` high, the registered `result` after the next rising edge is: ADD(0)=a+b, ADC(1)=a+b+CF, SUB(2)=a-b, SBB(3)=a-b-CF, AND(4), OR(5), XOR(6), truncated to the operand size. When `word_sel`=0, only bits 7:0 of each operand are used and `result[15:8]` is 0.
- R2: CF is the carry out of (addition) or the borrow into (subtraction) the top operand bit, which is bit 7 for bytes and bit 15 for words. OF flags a signed overflow at that same bit. ADC and SBB consume the CF held before the operation.
- R3: AF is the carry out of, or borrow into, bit 3 for arithmetic operations and compare. Logic operations clear AF.
- R4: ZF is set when the size-masked result is zero. SF copies its top bit (7 or 15). PF is set when `result[7:0]` holds an even number of ones, for either size.
- R5: AND, OR and XOR clear CF and OF.
- R6: CMP(7) sets every status flag exactly as SUB would, and `result` keeps its previous value.
- R7: Flag word layout: CF bit 0, PF bit 2, AF bit 4, ZF bit 6, SF bit 7, TF bit 8, IF bit 9, DF bit 10, OF bit 11. Bit 1 reads 1 and bits 3, 5 and 15:12 read 0. After reset, `flags`=16'h0002 and `result`=0.
- R8: `flag_cmd` codes are 1 clear CF, 2 set CF, 3 clear DF, 4 set DF, 5 clear IF, 6 set IF. Codes 0 and 7 do nothing. A command changes only the flag it names, one edge later.
- R9: Operations never change TF, IF or DF. TF stays 0.
- R10: If a CF command arrives in the same cycle as an operation, the command sets CF. The other status flags still come from the operation.
- R11: With `op_valid` low, `result` and the status flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Perform `op_code` this cycle |
| op_code | input | 3 | Operation select (see R1, R6) |
| word_sel | input | 1 | 1 = 16-bit operands, 0 = 8-bit |
| opnd_a | input | 16 | First operand (minuend) |
| opnd_b | input | 16 | Second operand (subtrahend) |
| flag_cmd | input | 3 | Control/carry flag command (see R8) |
| result | output | 16 | Registered result |
| flags | output | 16 | Flag word (see R7) |

## Verification
An operation and a flag command can land in the same cycle. For CF they compete to write the same bit. For DF and IF the command must be applied while the operation writes the other status flags.

The bench issues operations that produce a carry together with a clear-CF command, and operations that produce no carry together with a set-CF command. It also mixes random commands into random operations.

The reference model works out the operation's flags first and then applies the command. It compares every bit of the flag word after each edge. Any lost command, or any status flag dropped in the clash, therefore shows up.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int DATA_W = 16;
  localparam int HALF_W = DATA_W / 2;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
    OP_AND = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6, OP_CMP = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0, FC_CLR_C = 3'd1, FC_SET_C = 3'd2, FC_CLR_D = 3'd3,
    FC_SET_D = 3'd4, FC_CLR_I = 3'd5, FC_SET_I = 3'd6, FC_RSVD = 3'd7
  } flag_cmd_e;

  localparam int FB_CF = 0;
  localparam int FB_PF = 2;
  localparam int FB_AF = 4;
  localparam int FB_ZF = 6;
  localparam int FB_SF = 7;
  localparam int FB_TF = 8;
  localparam int FB_IF = 9;
  localparam int FB_DF = 10;
  localparam int FB_OF = 11;
  localparam int FB_ONE = 1;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } status_t;

  // Even-ones test on one byte
  function automatic logic even_ones(input logic [7:0] v);
    return ~(^v);
  endfunction

  // Top bit of a value under the selected operand size
  function automatic logic top_bit(input logic [DATA_W-1:0] v, input logic word);
    return word ? v[DATA_W-1] : v[HALF_W-1];
  endfunction

  // Signed overflow from operand and result sign bits
  function automatic logic sign_ovf(input logic sa, input logic sb,
                                    input logic sr, input logic sub);
    return sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  endfunction
endpackage

// File: rtl/afu_datapath.sv
module afu_datapath
  import afu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [2:0]   op,
  input  logic         word_sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output status_t      st
);
  localparam int H = W / 2;

  logic [W-1:0] a_m, b_m, logic_v, raw;
  logic [W:0]   ext_sum, ext_dif, ext_sel;
  logic [4:0]   nib_sum, nib_dif;
  logic         use_c, c_in, is_sub, is_logic, carry_out, ma, mb, mr;

  always_comb begin
    a_m      = word_sel ? a : {{H{1'b0}}, a[H-1:0]};
    b_m      = word_sel ? b : {{H{1'b0}}, b[H-1:0]};
    use_c    = (op == OP_ADC) || (op == OP_SBB);
    c_in     = use_c & cin;
    is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);

    ext_sum = {1'b0, a_m} + {1'b0, b_m} + {{W{1'b0}}, c_in};
    ext_dif = {1'b0, a_m} - {1'b0, b_m} - {{W{1'b0}}, c_in};
    nib_sum = {1'b0, a_m[3:0]} + {1'b0, b_m[3:0]} + {4'b0, c_in};
    nib_dif = {1'b0, a_m[3:0]} - {1'b0, b_m[3:0]} - {4'b0, c_in};

    case (op)
      OP_AND:  logic_v = a_m & b_m;
      OP_OR:   logic_v = a_m | b_m;
      default: logic_v = a_m ^ b_m;
    endcase

    ext_sel   = is_sub ? ext_dif : ext_sum;
    raw       = is_logic ? logic_v : ext_sel[W-1:0];
    res       = word_sel ? raw : {{H{1'b0}}, raw[H-1:0]};
    carry_out = word_sel ? ext_sel[W] : ext_sel[H];

    ma = top_bit(a_m, word_sel);
    mb = top_bit(b_m, word_sel);
    mr = top_bit(res, word_sel);

    st.cf = carry_out & ~is_logic;
    st.of = sign_ovf(ma, mb, mr, is_sub) & ~is_logic;
    st.af = (is_sub ? nib_dif[4] : nib_sum[4]) & ~is_logic;
    st.zf = (res == '0);
    st.sf = mr;
    st.pf = even_ones(res[7:0]);
  end
endmodule

// File: rtl/afu_flagreg.sv
module afu_flagreg
  import afu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        status_wr,
  input  status_t     st_in,
  input  logic [2:0]  cmd,
  output logic [15:0] flags
);
  status_t st_q;
  logic    df_q, ie_q;
  logic    carry_cmd;

  assign carry_cmd = (cmd == FC_CLR_C) || (cmd == FC_SET_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      df_q <= 1'b0;
      ie_q <= 1'b0;
    end else begin
      if (status_wr) st_q <= st_in;
      if (carry_cmd) st_q.cf <= (cmd == FC_SET_C);
      if (cmd == FC_CLR_D) df_q <= 1'b0;
      if (cmd == FC_SET_D) df_q <= 1'b1;
      if (cmd == FC_CLR_I) ie_q <= 1'b0;
      if (cmd == FC_SET_I) ie_q <= 1'b1;
    end
  end

  always_comb begin
    flags         = '0;
    flags[FB_ONE] = 1'b1;
    flags[FB_CF]  = st_q.cf;
    flags[FB_PF]  = st_q.pf;
    flags[FB_AF]  = st_q.af;
    flags[FB_ZF]  = st_q.zf;
    flags[FB_SF]  = st_q.sf;
    flags[FB_OF]  = st_q.of;
    flags[FB_TF]  = 1'b0;
    flags[FB_IF]  = ie_q;
    flags[FB_DF]  = df_q;
  end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_code,
  input  logic        word_sel,
  input  logic [15:0] opnd_a,
  input  logic [15:0] opnd_b,
  input  logic [2:0]  flag_cmd,
  output logic [15:0] result,
  output logic [15:0] flags
);
  logic [DATA_W-1:0] dp_res;
  status_t           dp_st;
  logic              res_wr;
  logic              status_wr;

  assign status_wr = op_valid;
  assign res_wr    = op_valid && (op_code != OP_CMP);

  afu_datapath #(.W(DATA_W)) u_dp (
    .op       (op_code),
    .word_sel (word_sel),
    .a        (opnd_a),
    .b        (opnd_b),
    .cin      (flags[FB_CF]),
    .res      (dp_res),
    .st       (dp_st)
  );

  afu_flagreg u_fr (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_wr (status_wr),
    .st_in     (dp_st),
    .cmd       (flag_cmd),
    .flags     (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result <= '0;
    else if (res_wr) result <= dp_res;
  end
endmodule

// File: rtl/afu_chk.sv
module afu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic [2:0]  flag_cmd,
  input logic        res_wr,
  input logic [15:0] result,
  input logic [15:0] flags
);
  // R8
  set_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cmd == 3'd2) |=> flags[0]);
  // R8
  clr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cmd == 3'd3) |=> !flags[10]);
  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cmd == 3'd0 || flag_cmd == 3'd1 || flag_cmd == 3'd2 || flag_cmd == 3'd7)
    |=> $stable(flags[10:8]));
  // R6
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd7) |=> $stable(result));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && (flag_cmd == 3'd0 || flag_cmd == 3'd7))
    |=> ($stable(flags) && $stable(result)));
  // R5
  logic_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 3'd4 && op_code <= 3'd6 && flag_cmd != 3'd2)
    |=> (!flags[0] && !flags[11]));
  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |=> (flags[6] == (result == 16'h0)));
endmodule

bind arith_flag_unit afu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .flag_cmd (flag_cmd),
  .res_wr   (res_wr),
  .result   (result),
  .flags    (flags)
);

// File: tb/arith_flag_unit_tb.sv
module arith_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic        word_sel = 1'b0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [2:0]  flag_cmd = '0;
  logic [15:0] result;
  logic [15:0] flags;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // model state
  int m_res = 0;
  int m_cf = 0, m_pf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_of = 0;
  int m_df = 0, m_if = 0;

  always #2 clk = ~clk;

  arith_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .word_sel(word_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .flag_cmd(flag_cmd), .result(result), .flags(flags)
  );

  function automatic int model_flags();
    int f;
    f = 2 + m_cf + 4*m_pf + 16*m_af + 64*m_zf + 128*m_sf
        + 512*m_if + 1024*m_df + 2048*m_of;
    return f;
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %04h expected %04h", tag, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at a falling edge, update the model, check at next falling edge
  task automatic step(input bit v, input int op, input bit w, input int a,
                      input int b, input int cmd, input string tag);
    int mask, sb, am, bm, c, r, full, ones, sa, sbb, sr;
    bit sub, lg;
    op_valid = v; op_code = op[2:0]; word_sel = w;
    opnd_a = a[15:0]; opnd_b = b[15:0]; flag_cmd = cmd[2:0];
    if (v) begin
      mask = w ? 'hFFFF : 'hFF;
      sb   = w ? 15 : 7;
      am = a & mask; bm = b & mask;
      c  = (op == 1 || op == 3) ? m_cf : 0;
      sub = (op == 2 || op == 3 || op == 7);
      lg  = (op >= 4 && op <= 6);
      if (lg) begin
        full = (op == 4) ? (am & bm) : (op == 5) ? (am | bm) : (am ^ bm);
        r = full; m_cf = 0; m_of = 0; m_af = 0;
      end else if (sub) begin
        full = am - bm - c;
        r = full & mask;
        m_cf = (full < 0) ? 1 : 0;
        m_af = (((am & 15) - (bm & 15) - c) < 0) ? 1 : 0;
      end else begin
        full = am + bm + c;
        r = full & mask;
        m_cf = (full > mask) ? 1 : 0;
        m_af = (((am & 15) + (bm & 15) + c) > 15) ? 1 : 0;
      end
      sa = (am >> sb) & 1; sbb = (bm >> sb) & 1; sr = (r >> sb) & 1;
      if (!lg) begin
        if (sub) m_of = (sa != sbb && sr != sa) ? 1 : 0;
        else     m_of = (sa == sbb && sr != sa) ? 1 : 0;
      end
      m_zf = (r == 0) ? 1 : 0;
      m_sf = sr;
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
      m_pf = (ones % 2 == 0) ? 1 : 0;
      if (op != 7) m_res = r;
    end
    case (cmd)
      1: m_cf = 0;
      2: m_cf = 1;
      3: m_df = 0;
      4: m_df = 1;
      5: m_if = 0;
      6: m_if = 1;
      default: ;
    endcase
    @(negedge clk);
    cmp({tag, " result"}, int'(result), m_res);
    cmp({tag, " flags"}, int'(flags), model_flags());
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    cmp("R7 reset result", int'(result), 0);
    cmp("R7 reset flags", int'(flags), 'h0002);
    rst_n = 1'b1;
    @(negedge clk);

    step(1, 0, 1, 'h1234, 'h1111, 0, "R1 word add");
    step(1, 0, 0, 'h12F0, 'h3420, 0, "R1 byte add upper ignored");
    step(1, 2, 1, 'h5000, 'h1234, 0, "R1 word sub");
    step(1, 4, 1, 'hF0F0, 'h3CC3, 0, "R1 and");
    step(1, 5, 0, 'h0012, 'h0081, 0, "R1 or");
    step(1, 6, 1, 'hFFFF, 'h00FF, 0, "R1 xor");
    step(1, 0, 0, 'h00FF, 'h0001, 0, "R2 byte carry");
    step(1, 1, 0, 'h0010, 'h0020, 0, "R2 adc uses carry");
    step(1, 0, 1, 'hFFFF, 'h0001, 0, "R2 word carry");
    step(1, 3, 1, 'h0005, 'h0005, 0, "R2 sbb borrow");
    step(1, 0, 0, 'h007F, 'h0001, 0, "R2 byte overflow");
    step(1, 0, 1, 'h7FFF, 'h0001, 0, "R2 word overflow");
    step(1, 2, 1, 'h8000, 'h0001, 0, "R2 word sub overflow");
    step(1, 0, 1, 'h000F, 'h0001, 0, "R3 nibble carry");
    step(1, 2, 0, 'h0010, 'h0001, 0, "R3 nibble borrow");
    step(1, 0, 1, 'h8000, 'h8000, 0, "R4 zero word");
    step(1, 2, 1, 'h0100, 'h0001, 0, "R4 sign parity");
    step(1, 0, 1, 'h0100, 'h0003, 0, "R4 parity low byte only");
    step(1, 0, 1, 'hFFFF, 'hFFFF, 0, "R5 setup carry");
    step(1, 5, 1, 'h8000, 'h0001, 0, "R5 logic clears CF OF");
    step(1, 0, 1, 'h4321, 'h0001, 0, "R6 setup");
    step(1, 7, 1, 'h0001, 'h0002, 0, "R6 compare");
    step(1, 7, 0, 'h0080, 'h0080, 0, "R6 compare equal");
    step(0, 0, 1, 0, 0, 2, "R8 set carry");
    step(0, 0, 1, 0, 0, 4, "R8 set dir");
    step(0, 0, 1, 0, 0, 6, "R8 set int");
    step(1, 4, 1, 'h0000, 'h0000, 0, "R9 op keeps control");
    step(0, 0, 1, 0, 0, 3, "R8 clear dir");
    step(0, 0, 1, 0, 0, 1, "R8 clear carry");
    step(0, 0, 1, 0, 0, 7, "R8 reserved code");
    step(1, 2, 1, 'h0009, 'h0001, 2, "R10 set carry beats op");
    step(1, 0, 0, 'h00FF, 'h00FF, 1, "R10 clear carry beats op");
    step(1, 0, 1, 'h1000, 'h2000, 4, "R10 dir cmd with op");
    step(0, 2, 1, 'hFFFF, 'h1234, 0, "R11 idle hold");
    step(0, 6, 0, 'h0000, 'h00FF, 0, "R11 idle hold again");

    for (int n = 0; n < 400; n++) begin
      int cmd;
      cmd = ($urandom % 4 == 0) ? int'($urandom % 8) : 0;
      step(($urandom % 8) != 0, int'($urandom % 8), $urandom % 2,
           int'($urandom % 65536), int'($urandom % 65536), cmd,
           "R1 R2 R3 R4 R10 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule